// File: doc/BRIEF.md
# Dual-Channel Timer Interrupt Aggregator

This block collects the event pulses of two timer channels and turns them into one maskable interrupt request per channel. Each channel keeps six sticky event flags (match A, B, C and D, overflow, underflow), a five-bit enable register and a control register. The control register holds a three-bit priority level and a read-only request bit. Software reaches all six registers through a small read/write port. It finds the cause of an interrupt by reading the flags, and it clears each flag itself.

A channel's request bit is a live function of its flags and enables; nothing holds it. The block compares the requesting channels against the global interrupt flag and the processor priority level. It presents at most one request to the CPU, together with the winning channel index. An acknowledge from the CPU is taken in one cycle and changes no state.

Top module: `tmr_irq_agg`

## Requirements
- R1: While rst_ni is low, every register reads 0 and irq_req_o is 0.
- R2: An event pulse on evt_i bit c*6+k sets flag k of channel c at the next rising edge, and the flag stays 1 until software clears it. The flag order is bit 0 match A, bit 1 match B, bit 2 match C, bit 3 match D, bit 4 overflow, bit 5 underflow.
- R3: A write to a status register clears each flag whose data bit is 0 and leaves a flag unchanged where the data bit is 1. If an event pulse and a clearing write hit the same flag in one cycle, the flag ends up set.
- R4: The request bit, bit 3 of the control register, is 1 exactly when some flag is 1 and its enable is 1. Enable bits 0 to 3 gate flags 0 to 3, and enable bit 4 gates both flag 4 and flag 5. The bit drops as soon as the flag or its enable is cleared, whether or not the interrupt was acknowledged.
- R5: Enable bits [4:0] and control bits [2:0] (the level) are read/write, and their other bits read 0. Writes to the request bit have no effect.
- R6: irq_req_o is 1 only when ien_i is 1 and some channel has its request bit set and a level strictly greater than ipl_i. Level 0 never requests.
- R7: When both channels qualify, the channel with the higher level is presented on irq_vec_o. On equal levels, channel 0 is presented.
- R8: irq_ack_i changes no flag and no other register.
- R9: Addresses 6 and 7 read 0, and writes to them change no register. The map is status 0 at address 0, status 1 at 1, enable 0 at 2, enable 1 at 3, control 0 at 4 and control 1 at 5.
- R10: The two channels are independent: an event or a write on one channel leaves the other channel's registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| evt_i | input | 12 | One-cycle event pulses, channel c at bits c*6+5..c*6 |
| reg_addr_i | input | 3 | Register address |
| reg_we_i | input | 1 | Register write enable |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational from reg_addr_i |
| ien_i | input | 1 | Global interrupt enable flag |
| ipl_i | input | 3 | Processor priority level |
| irq_req_o | output | 1 | Interrupt request to the CPU |
| irq_vec_o | output | 1 | Index of the presented channel |
| irq_ack_i | input | 1 | Interrupt acknowledge from the CPU |

## Verification
Event pulses and register writes are captured at a rising edge, and their effect is readable on reg_rdata_o and visible on irq_req_o in the cycle right after that edge. The level comparison and the channel choice are combinational, so a change of ien_i, ipl_i or reg_addr_i shows on the outputs in the same cycle. The bench therefore drives every input on the falling edge and samples one time unit later. A register result is compared only after exactly one rising edge has passed, and a priority result only after the inputs have settled.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
  localparam int unsigned NCH_D   = 2;
  localparam int unsigned NSRC_D  = 6;
  localparam int unsigned LVL_W_D = 3;
  localparam int unsigned DW_D    = 8;
  localparam int unsigned AW_D    = 3;

  typedef enum logic [1:0] {
    REG_STAT = 2'd0,
    REG_EN   = 2'd1,
    REG_CTL  = 2'd2,
    REG_NONE = 2'd3
  } reg_kind_e;
endpackage

// File: rtl/tmr_irq_chan.sv
module tmr_irq_chan #(
  parameter int unsigned NSRC  = 6,
  parameter int unsigned LVL_W = 3,
  parameter int unsigned DW    = 8,
  localparam int unsigned NMATCH = NSRC - 2,
  localparam int unsigned EN_W   = NMATCH + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NSRC-1:0]  evt_i,
  input  logic             stat_we_i,
  input  logic             en_we_i,
  input  logic             ctl_we_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [NSRC-1:0]  stat_o,
  output logic [EN_W-1:0]  en_o,
  output logic [LVL_W-1:0] lvl_o,
  output logic             req_o
);
  logic [NSRC-1:0]  stat_q, stat_d, keep_mask, en_mask;
  logic [EN_W-1:0]  en_q;
  logic [LVL_W-1:0] lvl_q;

  assign keep_mask = stat_we_i ? wdata_i[NSRC-1:0] : '1;
  // set has priority over a same-cycle clearing write
  assign stat_d = (stat_q & keep_mask) | evt_i;

  for (genvar k = 0; k < NSRC; k++) begin : g_mask
    if (k < NMATCH) begin : g_match
      assign en_mask[k] = en_q[k];
    end else begin : g_wrap
      assign en_mask[k] = en_q[NMATCH];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      en_q   <= '0;
      lvl_q  <= '0;
    end else begin
      stat_q <= stat_d;
      if (en_we_i)  en_q  <= wdata_i[EN_W-1:0];
      if (ctl_we_i) lvl_q <= wdata_i[LVL_W-1:0];
    end
  end

  assign req_o  = |(stat_q & en_mask);
  assign stat_o = stat_q;
  assign en_o   = en_q;
  assign lvl_o  = lvl_q;
endmodule

// File: rtl/tmr_irq_arb.sv
module tmr_irq_arb #(
  parameter int unsigned NCH   = 2,
  parameter int unsigned LVL_W = 3,
  localparam int unsigned CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                 ien_i,
  input  logic [LVL_W-1:0]     ipl_i,
  input  logic [NCH-1:0]       req_i,
  input  logic [NCH*LVL_W-1:0] lvl_i,
  output logic                 req_o,
  output logic [CH_W-1:0]      vec_o
);
  logic [LVL_W-1:0] best_lvl, cur_lvl;
  logic             found;
  logic [CH_W-1:0]  best_idx;

  always_comb begin
    found    = 1'b0;
    best_lvl = '0;
    best_idx = '0;
    for (int c = 0; c < NCH; c++) begin
      cur_lvl = lvl_i[c*LVL_W +: LVL_W];
      // strict compare keeps the lower index on a tie
      if (ien_i && req_i[c] && (cur_lvl > ipl_i) && (!found || cur_lvl > best_lvl)) begin
        found    = 1'b1;
        best_lvl = cur_lvl;
        best_idx = CH_W'(c);
      end
    end
  end

  assign req_o = found;
  assign vec_o = best_idx;
endmodule

// File: rtl/tmr_irq_agg.sv
module tmr_irq_agg
  import tmr_irq_pkg::*;
#(
  parameter int unsigned NCH   = NCH_D,
  parameter int unsigned NSRC  = NSRC_D,
  parameter int unsigned LVL_W = LVL_W_D,
  parameter int unsigned DW    = DW_D,
  parameter int unsigned AW    = AW_D,
  localparam int unsigned EN_W = NSRC - 1,
  localparam int unsigned CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NCH*NSRC-1:0] evt_i,
  input  logic [AW-1:0]       reg_addr_i,
  input  logic                reg_we_i,
  input  logic [DW-1:0]       reg_wdata_i,
  output logic [DW-1:0]       reg_rdata_o,
  input  logic                ien_i,
  input  logic [LVL_W-1:0]    ipl_i,
  output logic                irq_req_o,
  output logic [CH_W-1:0]     irq_vec_o,
  input  logic                irq_ack_i
);
  logic [NCH*NSRC-1:0]  stat_flat;
  logic [NCH*EN_W-1:0]  en_flat;
  logic [NCH*LVL_W-1:0] lvl_flat;
  logic [NCH-1:0]       chan_req;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    tmr_irq_chan #(.NSRC(NSRC), .LVL_W(LVL_W), .DW(DW)) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .evt_i     (evt_i[c*NSRC +: NSRC]),
      .stat_we_i (reg_we_i && reg_addr_i == AW'(c)),
      .en_we_i   (reg_we_i && reg_addr_i == AW'(NCH + c)),
      .ctl_we_i  (reg_we_i && reg_addr_i == AW'(2*NCH + c)),
      .wdata_i   (reg_wdata_i),
      .stat_o    (stat_flat[c*NSRC +: NSRC]),
      .en_o      (en_flat[c*EN_W +: EN_W]),
      .lvl_o     (lvl_flat[c*LVL_W +: LVL_W]),
      .req_o     (chan_req[c])
    );
  end

  reg_kind_e rd_kind;
  logic [CH_W-1:0] rd_ch;

  always_comb begin
    rd_kind = REG_NONE;
    rd_ch   = '0;
    for (int c = 0; c < NCH; c++) begin
      if (reg_addr_i == AW'(c))         begin rd_kind = REG_STAT; rd_ch = CH_W'(c); end
      if (reg_addr_i == AW'(NCH + c))   begin rd_kind = REG_EN;   rd_ch = CH_W'(c); end
      if (reg_addr_i == AW'(2*NCH + c)) begin rd_kind = REG_CTL;  rd_ch = CH_W'(c); end
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (rd_kind)
      REG_STAT: reg_rdata_o = DW'(stat_flat[rd_ch*NSRC +: NSRC]);
      REG_EN:   reg_rdata_o = DW'(en_flat[rd_ch*EN_W +: EN_W]);
      REG_CTL:  reg_rdata_o = DW'({chan_req[rd_ch], lvl_flat[rd_ch*LVL_W +: LVL_W]});
      default:  reg_rdata_o = '0;
    endcase
  end

  tmr_irq_arb #(.NCH(NCH), .LVL_W(LVL_W)) u_arb (
    .ien_i (ien_i),
    .ipl_i (ipl_i),
    .req_i (chan_req),
    .lvl_i (lvl_flat),
    .req_o (irq_req_o),
    .vec_o (irq_vec_o)
  );
endmodule

// File: rtl/tmr_irq_agg_chk.sv
module tmr_irq_agg_chk #(
  parameter int unsigned NCH   = 2,
  parameter int unsigned NSRC  = 6,
  parameter int unsigned LVL_W = 3,
  parameter int unsigned DW    = 8,
  parameter int unsigned AW    = 3,
  localparam int unsigned CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [NCH*NSRC-1:0]  evt_i,
  input logic [AW-1:0]        reg_addr_i,
  input logic                 reg_we_i,
  input logic [DW-1:0]        reg_wdata_i,
  input logic                 ien_i,
  input logic [LVL_W-1:0]     ipl_i,
  input logic                 irq_req_o,
  input logic [CH_W-1:0]      irq_vec_o,
  input logic                 irq_ack_i,
  input logic [NCH*NSRC-1:0]  stat_flat,
  input logic [NCH*LVL_W-1:0] lvl_flat,
  input logic [NCH-1:0]       chan_req
);
  for (genvar c = 0; c < NCH; c++) begin : g_c
    for (genvar k = 0; k < NSRC; k++) begin : g_k
      a_r2_event_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
        evt_i[c*NSRC+k] |=> stat_flat[c*NSRC+k]);
      a_r3_clear_by_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(stat_flat[c*NSRC+k]) |->
          $past(reg_we_i && reg_addr_i == AW'(c) && !reg_wdata_i[k] && !evt_i[c*NSRC+k]));
    end
    a_r7_no_better_loser: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_req_o && chan_req[c] && lvl_flat[c*LVL_W +: LVL_W] > ipl_i) |->
        lvl_flat[c*LVL_W +: LVL_W] <= lvl_flat[irq_vec_o*LVL_W +: LVL_W]);
  end

  a_r6_masked_by_ien: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ien_i |-> !irq_req_o);
  a_r6_level_above_ipl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |-> lvl_flat[irq_vec_o*LVL_W +: LVL_W] > ipl_i);
  a_r4_winner_requests: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |-> chan_req[irq_vec_o]);
  a_r8_ack_no_effect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ack_i && !reg_we_i && !(|evt_i)) |=> $stable(stat_flat));
endmodule

bind tmr_irq_agg tmr_irq_agg_chk #(
  .NCH(NCH), .NSRC(NSRC), .LVL_W(LVL_W), .DW(DW), .AW(AW)
) u_chk (.*);

// File: tb/tmr_irq_agg_tb.sv
module tmr_irq_agg_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] evt_i = '0;
  logic [2:0]  reg_addr_i = '0;
  logic        reg_we_i = 1'b0;
  logic [7:0]  reg_wdata_i = '0;
  logic [7:0]  reg_rdata_o;
  logic        ien_i = 1'b0;
  logic [2:0]  ipl_i = '0;
  logic        irq_req_o;
  logic [0:0]  irq_vec_o;
  logic        irq_ack_i = 1'b0;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  tmr_irq_agg u_dut (.*);

  // {ien, ipl, lvl0, lvl1, act0, act1, exp_req, exp_vec}
  localparam logic [13:0] VECS [12] = '{
    {1'b1, 3'd0, 3'd3, 3'd5, 1'b1, 1'b1, 1'b1, 1'b1},
    {1'b1, 3'd0, 3'd5, 3'd3, 1'b1, 1'b1, 1'b1, 1'b0},
    {1'b1, 3'd0, 3'd4, 3'd4, 1'b1, 1'b1, 1'b1, 1'b0},
    {1'b0, 3'd0, 3'd4, 3'd4, 1'b1, 1'b1, 1'b0, 1'b0},
    {1'b1, 3'd4, 3'd4, 3'd4, 1'b1, 1'b1, 1'b0, 1'b0},
    {1'b1, 3'd3, 3'd4, 3'd2, 1'b1, 1'b1, 1'b1, 1'b0},
    {1'b1, 3'd3, 3'd2, 3'd4, 1'b1, 1'b1, 1'b1, 1'b1},
    {1'b1, 3'd0, 3'd0, 3'd1, 1'b1, 1'b1, 1'b1, 1'b1},
    {1'b1, 3'd0, 3'd7, 3'd7, 1'b0, 1'b1, 1'b1, 1'b1},
    {1'b1, 3'd0, 3'd0, 3'd0, 1'b1, 1'b1, 1'b0, 1'b0},
    {1'b1, 3'd6, 3'd7, 3'd7, 1'b1, 1'b0, 1'b1, 1'b0},
    {1'b1, 3'd7, 3'd7, 3'd7, 1'b1, 1'b1, 1'b0, 1'b0}
  };

  task automatic chk(string req, int act, int exp, string what);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk_i);
    reg_addr_i = a; reg_we_i = 1'b1; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, int exp, string req, string what);
    reg_addr_i = a;
    #1;
    chk(req, int'(reg_rdata_o), exp, what);
  endtask

  task automatic pulse(logic [11:0] e);
    @(negedge clk_i);
    evt_i = e;
    @(negedge clk_i);
    evt_i = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R1 reset state
    repeat (2) @(negedge clk_i);
    evt_i = '1;
    @(negedge clk_i);
    evt_i = '0;
    for (int a = 0; a < 8; a++) rd(3'(a), 0, "R1", "reg during reset");
    chk("R1", int'(irq_req_o), 0, "irq_req during reset");
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R2 set and sticky; R10 other channel untouched
    pulse(12'h004);
    rd(3'd0, 8'h04, "R2", "status0 after event C");
    rd(3'd1, 8'h00, "R10", "status1 untouched");
    repeat (3) @(negedge clk_i);
    rd(3'd0, 8'h04, "R2", "status0 sticky");

    // R4 request follows enable
    rd(3'd4, 8'h00, "R4", "ctrl0 without enable");
    wr(3'd2, 8'h04);
    rd(3'd4, 8'h08, "R4", "ctrl0 request set");

    // R3 write-1 keeps, write-0 clears; R4 drops without ack
    wr(3'd0, 8'hFF);
    rd(3'd0, 8'h04, "R3", "status0 after write 1s");
    wr(3'd0, 8'hFB);
    rd(3'd0, 8'h00, "R3", "status0 after clear");
    rd(3'd4, 8'h00, "R4", "ctrl0 drops after clear");

    // R4 overflow enable gates underflow
    pulse(12'h020);
    rd(3'd0, 8'h20, "R2", "status0 underflow");
    rd(3'd4, 8'h00, "R4", "underflow masked by match enable");
    wr(3'd2, 8'h10);
    rd(3'd4, 8'h08, "R4", "underflow via overflow enable");
    wr(3'd2, 8'hFF);
    rd(3'd2, 8'h1F, "R5", "enable0 width");
    wr(3'd2, 8'h00);
    rd(3'd4, 8'h00, "R4", "drops on enable clear");

    // R3 set wins over clear
    @(negedge clk_i);
    evt_i = 12'h001; reg_addr_i = 3'd0; reg_we_i = 1'b1; reg_wdata_i = 8'h00;
    @(negedge clk_i);
    evt_i = '0; reg_we_i = 1'b0;
    rd(3'd0, 8'h01, "R3", "set wins, other flag cleared");

    // R5 request bit read-only
    wr(3'd4, 8'hFF);
    rd(3'd4, 8'h07, "R5", "ctrl0 level only");
    wr(3'd4, 8'h08);
    rd(3'd4, 8'h00, "R5", "ctrl0 request not writable");

    // R9 unmapped addresses
    wr(3'd6, 8'hFF);
    wr(3'd7, 8'hFF);
    rd(3'd6, 0, "R9", "addr 6");
    rd(3'd7, 0, "R9", "addr 7");
    rd(3'd0, 8'h01, "R9", "status0 after unmapped writes");
    rd(3'd2, 8'h00, "R9", "enable0 after unmapped writes");
    rd(3'd5, 8'h00, "R9", "ctrl1 after unmapped writes");

    // R6 / R8
    wr(3'd2, 8'h01);
    wr(3'd4, 8'h02);
    ien_i = 1'b1; ipl_i = 3'd1;
    #1;
    chk("R6", int'(irq_req_o), 1, "level above ipl");
    chk("R7", int'(irq_vec_o), 0, "vector channel 0");
    @(negedge clk_i);
    irq_ack_i = 1'b1;
    @(negedge clk_i);
    irq_ack_i = 1'b0;
    rd(3'd0, 8'h01, "R8", "status0 after ack");
    chk("R8", int'(irq_req_o), 1, "request held after ack");
    ipl_i = 3'd2;
    #1;
    chk("R6", int'(irq_req_o), 0, "level equal ipl");
    ien_i = 1'b0;

    // R10 channel 1 event
    pulse(12'h400);
    rd(3'd1, 8'h10, "R10", "status1 overflow");
    rd(3'd0, 8'h01, "R10", "status0 unaffected");

    // table of priority vectors
    pulse(12'hFFF);
    for (int i = 0; i < 12; i++) begin
      logic [13:0] v;
      v = VECS[i];
      wr(3'd4, {5'd0, v[9:7]});
      wr(3'd5, {5'd0, v[6:4]});
      wr(3'd2, v[3] ? 8'h1F : 8'h00);
      wr(3'd3, v[2] ? 8'h1F : 8'h00);
      ien_i = v[13]; ipl_i = v[12:10];
      #1;
      chk("R6", int'(irq_req_o), int'(v[1]), $sformatf("vector %0d request", i));
      if (v[1]) chk("R7", int'(irq_vec_o), int'(v[0]), $sformatf("vector %0d channel", i));
      @(negedge clk_i);
    end

    finish_run();
  end
endmodule